// File: doc/BRIEF.md
# Up-Down PWM Timebase with Conversion Trigger

This block is a PWM time base whose counter climbs from zero to a programmable period and falls back to zero, repeating for as long as a global count enable is held high. Several copies can share that enable, so that their counters start on the same clock. The period is written into a shadow register and is copied into the active register only when the counter stands at zero, so a period change never cuts a ramp short.

From the counter, an event stage picks a qualifying event: either the turnaround at the top of the ramp, or the counter leaving zero. A small prescaler passes one of every one, two or three events as a one-clock trigger pulse, which is meant to start a converter sequencer. Each trigger also sets a sticky event flag that software clears with a strobe.

Top module: `pwm_updown_trig`

## Requirements
- R1: After reset the counter reads 0, the trigger and the flag are low, and the active period is 0, so the counter holds at 0 until a non-zero period has been written and loaded.
- R2: On each clock with `sync_en` high the counter moves by one: upward from 0 to the active period P, then downward to 0, then upward again. The value P is shown for one clock only, so a full cycle takes 2P clocks. An active period of 0 holds the counter at 0.
- R3: A write strobe stores `prd_wdata` in the shadow period. The active period takes the shadow value only on an enabled clock on which the counter is 0. A write made partway up a ramp leaves that ramp's peak unchanged.
- R4: While `sync_en` is low the counter and direction hold their values and no event is produced.
- R5: `evt_sel` chooses the event source. Code 2'b10 is the counter equal to the active period while counting up. Code 2'b01 is the counter leaving zero (counter 0 with a non-zero shadow period). Codes 2'b00 and 2'b11 select no event.
- R6: With `evt_en` low no trigger is produced and the prescale count is cleared.
- R7: `evt_div` gives the events per trigger. Value 0 never triggers. Values 1, 2 and 3 trigger on every first, second or third event. The event count restarts after each trigger.
- R8: The trigger is a one-clock pulse. It is high in the clock after the one on which the counter shows the matching value, and it is never high on two clocks in a row.
- R9: The event flag is set together with each trigger and holds until `flag_clr` is strobed. A trigger in the same clock as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_en | input | 1 | Global count enable shared by all timebases |
| prd_wr | input | 1 | Shadow period write strobe |
| prd_wdata | input | CNT_W | Period value to write |
| evt_sel | input | 2 | Event source code (see R5) |
| evt_en | input | 1 | Trigger enable |
| evt_div | input | DIV_W | Events per trigger (see R7) |
| flag_clr | input | 1 | Clears the event flag |
| cnt_o | output | CNT_W | Counter value |
| dir_down_o | output | 1 | High while counting down |
| trig_o | output | 1 | Conversion trigger pulse |
| flag_o | output | 1 | Sticky event flag |

## Verification
The counter value is registered, so it is due one clock after each enabled edge. The trigger and the flag are due one clock after the edge on which the counter held the matching value, which means they appear while the counter already shows the next value (P-1 for the period event). A period write becomes visible only at the next zero of the counter, which can be up to 2P clocks later. The bench drives inputs and samples outputs at the falling edge, so every sample sees the result of exactly the rising edges counted so far, and each expected value is indexed to that edge count.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_ZERO = 2'b01,
        SRC_PRD  = 2'b10,
        SRC_RSVD = 2'b11
    } evt_src_e;

endpackage

// File: rtl/pwm_updown_cnt.sv
module pwm_updown_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             prd_wr,
    input  logic [CNT_W-1:0] prd_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic             prd_hit,
    output logic             zero_hit
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] shd;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        prd_hit  = 1'b0;
        zero_hit = 1'b0;
        if (prd_wr) begin
            st_d.shd = prd_wdata;
        end
        if (tick) begin
            if (st_q.cnt == '0) begin
                // bottom of the ramp: load the shadow period here
                st_d.act  = st_q.shd;
                st_d.down = 1'b0;
                if (st_q.shd != '0) begin
                    st_d.cnt = ONE;
                    zero_hit = 1'b1;
                end
            end else if (!st_q.down && (st_q.cnt >= st_q.act)) begin
                // top of the ramp: turn around immediately
                st_d.down = 1'b1;
                st_d.cnt  = st_q.cnt - ONE;
                prd_hit   = 1'b1;
            end else if (st_q.down) begin
                st_d.cnt = st_q.cnt - ONE;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign down = st_q.down;
endmodule

// File: rtl/pwm_evt_mux.sv
module pwm_evt_mux
    import pwm_tbase_pkg::*;
(
    input  logic [1:0] evt_sel,
    input  logic       prd_hit,
    input  logic       zero_hit,
    output logic       evt
);
    evt_src_e src;

    always_comb begin
        src = evt_src_e'(evt_sel);
        unique case (src)
            SRC_PRD:  evt = prd_hit;
            SRC_ZERO: evt = zero_hit;
            default:  evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_evt_prescale.sv
module pwm_evt_prescale #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             evt_en,
    input  logic [DIV_W-1:0] evt_div,
    input  logic             flag_clr,
    output logic             trig,
    output logic             flag
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DIV_W-1:0] pc;
        logic             trig;
        logic             flag;
    } psc_st_t;

    psc_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.trig = 1'b0;
        if (!evt_en || (evt_div == '0)) begin
            st_d.pc = '0;
        end else if (evt) begin
            if ((st_q.pc + ONE) >= evt_div) begin
                st_d.trig = 1'b1;
                st_d.pc   = '0;
            end else begin
                st_d.pc = st_q.pc + ONE;
            end
        end
        if (st_d.trig) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig = st_q.trig;
    assign flag = st_q.flag;
endmodule

// File: rtl/pwm_updown_trig.sv
module pwm_updown_trig #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_en,
    input  logic             prd_wr,
    input  logic [CNT_W-1:0] prd_wdata,
    input  logic [1:0]       evt_sel,
    input  logic             evt_en,
    input  logic [DIV_W-1:0] evt_div,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_down_o,
    output logic             trig_o,
    output logic             flag_o
);
    logic prd_hit, zero_hit, evt;

    pwm_updown_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sync_en),
        .prd_wr    (prd_wr),
        .prd_wdata (prd_wdata),
        .cnt       (cnt_o),
        .down      (dir_down_o),
        .prd_hit   (prd_hit),
        .zero_hit  (zero_hit)
    );

    pwm_evt_mux u_mux (
        .evt_sel  (evt_sel),
        .prd_hit  (prd_hit),
        .zero_hit (zero_hit),
        .evt      (evt)
    );

    pwm_evt_prescale #(.DIV_W(DIV_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .evt_en   (evt_en),
        .evt_div  (evt_div),
        .flag_clr (flag_clr),
        .trig     (trig_o),
        .flag     (flag_o)
    );
endmodule

// File: rtl/pwm_updown_trig_chk.sv
module pwm_updown_trig_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_en,
    input logic             evt_en,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cnt_o,
    input logic             trig_o,
    input logic             flag_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R8
    trig_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R9
    flag_with_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> flag_o);

    // R9
    flag_drop_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(flag_clr));

    // R4
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |=> $stable(cnt_o));

    // R2
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en |=> (((cnt_o - $past(cnt_o)) == ONE) || (($past(cnt_o) - cnt_o) == ONE)
                     || ((cnt_o == '0) && ($past(cnt_o) == '0))));

    // R6
    trig_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(evt_en));
endmodule

bind pwm_updown_trig pwm_updown_trig_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_en  (sync_en),
    .evt_en   (evt_en),
    .flag_clr (flag_clr),
    .cnt_o    (cnt_o),
    .trig_o   (trig_o),
    .flag_o   (flag_o)
);

// File: tb/pwm_updown_trig_tb.sv
module pwm_updown_trig_tb;
    localparam int CNT_W = 16;
    localparam int DIV_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sync_en = 1'b0;
    logic             prd_wr = 1'b0;
    logic [CNT_W-1:0] prd_wdata = '0;
    logic [1:0]       evt_sel = 2'b00;
    logic             evt_en = 1'b0;
    logic [DIV_W-1:0] evt_div = '0;
    logic             flag_clr = 1'b0;
    logic [CNT_W-1:0] cnt_o;
    logic             dir_down_o, trig_o, flag_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_updown_trig #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .prd_wr(prd_wr),
        .prd_wdata(prd_wdata), .evt_sel(evt_sel), .evt_en(evt_en),
        .evt_div(evt_div), .flag_clr(flag_clr), .cnt_o(cnt_o),
        .dir_down_o(dir_down_o), .trig_o(trig_o), .flag_o(flag_o)
    );

    // period, source code, enable, events per trigger, enabled clocks, expected triggers
    typedef struct packed {
        logic [15:0] prd;
        logic [1:0]  sel;
        logic        en;
        logic [1:0]  div;
        logic [15:0] n;
        logic [7:0]  exp_trig;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'd4, 2'b10, 1'b1, 2'd1, 16'd40, 8'd5},   // R5 period source
        '{16'd4, 2'b01, 1'b1, 2'd1, 16'd40, 8'd5},   // R5 zero source
        '{16'd3, 2'b10, 1'b1, 2'd2, 16'd60, 8'd5},   // R7 every second
        '{16'd2, 2'b01, 1'b1, 2'd3, 16'd50, 8'd4},   // R7 every third
        '{16'd5, 2'b10, 1'b0, 2'd1, 16'd40, 8'd0},   // R6 disabled
        '{16'd1, 2'b10, 1'b1, 2'd1, 16'd20, 8'd10},  // R2 period one
        '{16'd6, 2'b00, 1'b1, 2'd1, 16'd40, 8'd0},   // R5 no source
        '{16'd3, 2'b10, 1'b1, 2'd0, 16'd30, 8'd0},   // R7 divider zero
        '{16'd4, 2'b11, 1'b1, 2'd1, 16'd40, 8'd0}    // R5 reserved code
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic start(input int prd, input logic [1:0] sel, input logic en, input int div);
        rst_n = 1'b0; sync_en = 1'b0; prd_wr = 1'b0; flag_clr = 1'b0;
        step(); step();
        rst_n = 1'b1;
        evt_sel = sel; evt_en = en; evt_div = DIV_W'(div);
        prd_wdata = CNT_W'(prd); prd_wr = 1'b1;
        step();
        prd_wr = 1'b0;
        sync_en = 1'b1;
    endtask

    function automatic int tri_val(input int n, input int p);
        int m;
        m = n % (2 * p);
        return (m <= p) ? m : (2 * p - m);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        rst_n = 1'b0;
        step(); step();
        check(cnt_o == '0, "R1 cnt", int'(cnt_o), 0);
        check(!trig_o && !flag_o, "R1 trig/flag", int'(trig_o | flag_o), 0);
        rst_n = 1'b1; sync_en = 1'b1; evt_sel = 2'b01; evt_en = 1'b1; evt_div = 2'd1;
        repeat (5) step();
        check(cnt_o == '0 && !trig_o, "R1 holds at zero without period", int'(cnt_o), 0);

        // table of trigger counts: R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            int trigs;
            trigs = 0;
            start(int'(VECS[v].prd), VECS[v].sel, VECS[v].en, int'(VECS[v].div));
            for (int i = 0; i < int'(VECS[v].n); i++) begin
                step();
                if (trigs >= 0 && trig_o) trigs++;
            end
            sync_en = 1'b0;
            step();
            if (trig_o) trigs++;
            check(trigs == int'(VECS[v].exp_trig), $sformatf("R5 R6 R7 vector %0d", v),
                  trigs, int'(VECS[v].exp_trig));
        end

        // R2 R8 exact timing, period 3, period source
        start(3, 2'b10, 1'b1, 1);
        for (int n = 1; n <= 16; n++) begin
            step();
            check(int'(cnt_o) == tri_val(n, 3), "R2 count sequence", int'(cnt_o), tri_val(n, 3));
            check(trig_o == (tri_val(n - 1, 3) == 3), "R8 trigger timing",
                  int'(trig_o), int'(tri_val(n - 1, 3) == 3));
        end

        // R9 flag holds, then clears
        sync_en = 1'b0;
        repeat (3) step();
        check(flag_o == 1'b1, "R9 flag held", int'(flag_o), 1);
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        check(flag_o == 1'b0, "R9 flag cleared", int'(flag_o), 0);

        // R4 frozen counter
        begin
            logic [CNT_W-1:0] held;
            held = cnt_o;
            repeat (5) step();
            check(cnt_o == held && !trig_o, "R4 frozen", int'(cnt_o), int'(held));
        end

        // R3 shadow load at zero
        begin
            int pk1, pk2;
            pk1 = 0; pk2 = 0;
            start(4, 2'b10, 1'b1, 1);
            step(); step();
            prd_wdata = CNT_W'(2); prd_wr = 1'b1;
            step();
            prd_wr = 1'b0;
            for (int i = 0; i < 20; i++) begin
                if (int'(cnt_o) > pk1) pk1 = int'(cnt_o);
                step();
                if (cnt_o == '0) break;
            end
            for (int i = 0; i < 20; i++) begin
                step();
                if (int'(cnt_o) > pk2) pk2 = int'(cnt_o);
                if (cnt_o == '0) break;
            end
            check(pk1 == 4, "R3 old peak kept", pk1, 4);
            check(pk2 == 2, "R3 new peak after zero", pk2, 2);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule